// File: doc/BRIEF.md
# Double-Buffered Byte Serial Transmitter

This block sends bytes on one serial output line. A CPU-side write port fills a one-byte holding stage. A separate shift stage takes each byte from there and drives it out as an asynchronous frame. Because there are two stages, the CPU can supply the next byte while the current one is still going out.

Bit timing comes from a single-cycle enable pulse, `ser_tick`, produced by an external divider. The transmitter never restarts or re-phases that pulse. A byte copied into the shift stage therefore waits for the next pulse before its start bit appears. The transmitter has two interrupt-request flags, each with its own enable and acknowledge:

- The "need" flag asks for another byte. It fires at the moment the holding stage is copied into the shift stage, not at the end of a byte.
- The "done" flag reports that the line has gone idle after a stop bit, with nothing waiting to be sent.

Top module: `dbl_buf_serial_tx`

## Requirements
- R1: After reset, `txd` is 1 (idle), `hold_full` is 0 and both interrupt outputs are 0. Whenever the shift stage is empty, `txd` is 1.
- R2: Each byte goes out as one start bit at 0, then eight data bits with the least significant bit first, then one stop bit at 1. Each bit lasts one `ser_tick` period.
- R3: A write to an empty holding stage while the shift stage is idle behaves as follows. After the write's clock edge, `hold_full` is 1 and `irq_need` is still 0. After the following edge, the byte has been copied, `hold_full` is 0 and the need flag is set. The need flag is only ever set by such a copy.
- R4: The done flag is set at the tick that ends a stop bit, but only if the holding stage was empty before that edge. If a byte was waiting at that edge, the done flag keeps its previous value.
- R5: `txd` changes only at clock edges where `ser_tick` is 1. After a copy, the start bit waits for the next tick.
- R6: If a byte is waiting when the stop bit ends, it is copied at that same tick and raises the need flag again. Its start bit follows at the next tick, so the two start bits are 11 bit periods apart.
- R7: A write while `hold_full` is 1 replaces the waiting byte. The replaced byte is never sent.
- R8: `irq_need` is the need flag ANDed with `en_need`, and `irq_done` is the done flag ANDed with `en_done`. A flag stays set while it is masked.
- R9: A high `ack_need` or `ack_done` clears its flag at the next edge. If the flag is set and acknowledged in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Byte to send |
| ser_tick | input | 1 | Free-running one-cycle bit-rate enable |
| en_need | input | 1 | Enable for the need interrupt |
| en_done | input | 1 | Enable for the done interrupt |
| ack_need | input | 1 | Clears the need flag |
| ack_done | input | 1 | Clears the done flag |
| txd | output | 1 | Serial output line, idles high |
| irq_need | output | 1 | Masked request for the next byte |
| irq_done | output | 1 | Masked transmission-complete request |
| hold_full | output | 1 | Holding stage holds a byte not yet copied |

## Verification
The bench targets the following corner cases, each paired with the way a wrong design would show it:

- **Timing of the first copy.** A design that raises the need request in the same cycle as the write, or only at the end of the byte, is caught by cycle-exact sampling around a write to an idle transmitter.
- **Start bit before a tick.** A design that drives the start bit before a tick, or resets the bit clock, makes `txd` move on an edge without `ser_tick` high. A monitor catches this on every edge.
- **Back-to-back frames.** A design that inserts extra gaps, or raises the done request while a byte waits, misses the 11-period start spacing or the done expectation at frame end.
- **Overwrite and flag handling.** An overwrite that still sends the lost byte, a flag that ack wins over on a same-cycle set, or a flag lost while masked each give a wrong byte or a wrong `irq_need` level.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 2;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_ARMED = 2'd1,
        SH_SEND  = 2'd2
    } sh_state_e;

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output hold_t             hold
);

    hold_t hold_q;

    // A write always wins over a take, so a byte written in the cycle of a copy is kept.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (wr_en) begin
            hold_q.data <= wr_data;
            hold_q.full <= 1'b1;
        end else if (take) begin
            hold_q.full <= 1'b0;
        end
    end

    assign hold = hold_q;

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         txd,
    output logic         busy,
    output logic         frame_end
);

    localparam int LAST = W + 1;
    localparam int CW   = $clog2(W + 2);

    sh_state_e       state_q;
    logic [W-1:0]    sh_q;
    logic [CW-1:0]   cnt_q;
    logic            txd_q;

    assign frame_end = (state_q == SH_SEND) && tick && (cnt_q == CW'(LAST));
    assign busy      = (state_q != SH_IDLE);
    assign txd       = txd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            txd_q   <= 1'b1;
        end else if (load) begin
            state_q <= SH_ARMED;
            sh_q    <= load_data;
            cnt_q   <= '0;
            txd_q   <= 1'b1;
        end else begin
            case (state_q)
                SH_ARMED: begin
                    if (tick) begin
                        txd_q   <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= SH_SEND;
                    end
                end
                SH_SEND: begin
                    if (frame_end) begin
                        state_q <= SH_IDLE;
                    end else if (tick) begin
                        // Ones shift in from the top, so the stop bit follows the data.
                        txd_q <= sh_q[0];
                        sh_q  <= {1'b1, sh_q[W-1:1]};
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sertx_irq_flag.sv
module sertx_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    input  logic en,
    output logic flag,
    output logic irq
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (ack) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
    assign irq  = flag_q & en;

endmodule

// File: rtl/dbl_buf_serial_tx.sv
module dbl_buf_serial_tx
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ser_tick,
    input  logic              en_need,
    input  logic              en_done,
    input  logic              ack_need,
    input  logic              ack_done,
    output logic              txd,
    output logic              irq_need,
    output logic              irq_done,
    output logic              hold_full
);

    localparam int NFLAG = 2;

    hold_t hold;
    logic  sh_busy;
    logic  frame_end;
    logic  take;
    logic  need_flag;
    logic  done_flag;

    logic [NFLAG-1:0] f_set, f_ack, f_en, f_flag, f_irq;

    // Copy whenever the shifter is empty, or at the tick that ends its stop bit.
    assign take = hold.full && (!sh_busy || frame_end);

    sertx_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .hold    (hold)
    );

    sertx_shift #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (ser_tick),
        .load      (take),
        .load_data (hold.data),
        .txd       (txd),
        .busy      (sh_busy),
        .frame_end (frame_end)
    );

    // Index 0: need flag, index 1: done flag.
    assign f_set = {frame_end && !take, take};
    assign f_ack = {ack_done, ack_need};
    assign f_en  = {en_done, en_need};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        sertx_irq_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (f_set[g]),
            .ack  (f_ack[g]),
            .en   (f_en[g]),
            .flag (f_flag[g]),
            .irq  (f_irq[g])
        );
    end

    assign need_flag = f_flag[0];
    assign done_flag = f_flag[1];
    assign irq_need  = f_irq[0];
    assign irq_done  = f_irq[1];
    assign hold_full = hold.full;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic ack_need,
    input logic ser_tick,
    input logic en_need,
    input logic hold_full,
    input logic sh_busy,
    input logic take,
    input logic txd,
    input logic need_flag,
    input logic done_flag,
    input logic irq_need
);

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !sh_busy |-> txd); // R1

    AST_WRITE_FIRST_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hold_full && !sh_busy) |=> (hold_full && !sh_busy)); // R3

    AST_COPY_SETS_NEED: assert property (@(posedge clk) disable iff (rst)
        take |=> (need_flag && sh_busy)); // R3

    AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> $past(ser_tick)); // R5

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> !sh_busy); // R4

    AST_MASK_NEED: assert property (@(posedge clk) disable iff (rst)
        !en_need |-> !irq_need); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack_need && !take) |=> !need_flag); // R9

    AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
        (ack_need && take) |=> need_flag); // R9

endmodule

bind dbl_buf_serial_tx sertx_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .ack_need  (ack_need),
    .ser_tick  (ser_tick),
    .en_need   (en_need),
    .hold_full (hold_full),
    .sh_busy   (sh_busy),
    .take      (take),
    .txd       (txd),
    .need_flag (need_flag),
    .done_flag (done_flag),
    .irq_need  (irq_need)
);

// File: tb/dbl_buf_serial_tx_tb_top.sv
module dbl_buf_serial_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICKP      = 8;
    localparam int WDOG       = 100000;
    localparam int N_RAND     = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ser_tick = 1'b0;
    logic       en_need = 1'b1;
    logic       en_done = 1'b1;
    logic       ack_need = 1'b0;
    logic       ack_done = 1'b0;
    logic       txd, irq_need, irq_done, hold_full;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int tcnt = 0;

    logic [7:0] exp_q[$];

    // monitor state
    int         cyc = 0;
    int         mstate = 0;
    int         bitn = 0;
    logic [7:0] cap = '0;
    int         last_start = -1;
    bit         b2b_next = 1'b0;
    logic       p_txd = 1'b1, p_need = 1'b0, p_done = 1'b0, p_full = 1'b0, p_en_need = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbl_buf_serial_tx dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ser_tick(ser_tick),
        .en_need(en_need), .en_done(en_done), .ack_need(ack_need), .ack_done(ack_done),
        .txd(txd), .irq_need(irq_need), .irq_done(irq_done), .hold_full(hold_full)
    );

    // free-running bit-rate enable, never touched by the stimulus
    always @(negedge clk) begin
        tcnt     <= (tcnt == TICKP-1) ? 0 : tcnt + 1;
        ser_tick <= (tcnt == TICKP-1);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int b2i(input logic b);
        return (b === 1'b1) ? 1 : 0;
    endfunction

    // monitor: samples just after each rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst) begin
            mstate = 0;
        end else begin
            if (txd !== p_txd)
                chk(ser_tick === 1'b1, "R5 txd moved without tick", b2i(ser_tick), 1);
            if (irq_need && !p_need && p_en_need)
                chk(p_full === 1'b1, "R3 need set without copy", b2i(p_full), 1);
            if (mstate == 0) begin
                if (p_txd && !txd) begin
                    if (b2b_next)
                        chk(cyc - last_start == 11*TICKP, "R6 start spacing",
                            cyc - last_start, 11*TICKP);
                    b2b_next   = 1'b0;
                    last_start = cyc;
                    mstate     = 1;
                    bitn       = 0;
                end
            end else if (ser_tick) begin
                bitn++;
                if (bitn <= 8) cap[bitn-1] = txd;
                else if (bitn == 9) chk(txd === 1'b1, "R2 stop bit", b2i(txd), 1);
                else begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 R7 unexpected frame", cap, -1);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(cap === e, "R2 R7 frame data", cap, e);
                    end
                    if (en_done) begin
                        if (!p_full) chk(irq_done === 1'b1, "R4 done at frame end", b2i(irq_done), 1);
                        else chk(irq_done === p_done, "R4 done kept while byte waits",
                                 b2i(irq_done), b2i(p_done));
                    end
                    b2b_next = p_full;
                    mstate   = 0;
                end
            end
        end
        p_txd = txd; p_need = irq_need; p_done = irq_done; p_full = hold_full; p_en_need = en_need;
    end

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack(input bit need, input bit done);
        @(negedge clk);
        ack_need = need; ack_done = done;
        @(negedge clk);
        ack_need = 1'b0; ack_done = 1'b0;
    endtask

    task automatic wait_drain();
        int n = 0;
        while ((exp_q.size() != 0 || hold_full || mstate != 0) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(txd === 1'b1, "R1 txd idle", b2i(txd), 1);
        chk(hold_full === 1'b0, "R1 hold empty", b2i(hold_full), 0);
        chk(irq_need === 1'b0 && irq_done === 1'b0, "R1 irqs clear", b2i(irq_need|irq_done), 0);

        // R3: two-step copy after a write to an idle transmitter
        exp_q.push_back(8'hA5);
        do_write(8'hA5);
        chk(hold_full === 1'b1, "R3 full after write", b2i(hold_full), 1);
        chk(irq_need === 1'b0, "R3 need not in write cycle", b2i(irq_need), 0);
        @(posedge clk); #1;
        chk(hold_full === 1'b0, "R3 copied next edge", b2i(hold_full), 0);
        chk(irq_need === 1'b1, "R3 need after copy", b2i(irq_need), 1);
        wait_drain();
        chk(irq_done === 1'b1, "R4 done after lone frame", b2i(irq_done), 1);

        // R9: ack clears need and done
        pulse_ack(1'b1, 1'b1);
        chk(irq_need === 1'b0, "R9 need acked", b2i(irq_need), 0);
        chk(irq_done === 1'b0, "R9 done acked", b2i(irq_done), 0);

        // R9: set and ack in the same cycle keep the flag
        exp_q.push_back(8'h3C);
        do_write(8'h3C);
        ack_need = 1'b1;
        @(posedge clk); #1;
        chk(irq_need === 1'b1, "R9 set beats ack", b2i(irq_need), 1);
        @(negedge clk);
        ack_need = 1'b0;
        wait_drain();
        pulse_ack(1'b1, 1'b1);

        // R8: mask holds the flag back, unmasking shows it
        en_need = 1'b0;
        exp_q.push_back(8'h81);
        do_write(8'h81);
        repeat (3) @(negedge clk);
        chk(irq_need === 1'b0, "R8 masked need", b2i(irq_need), 0);
        en_need = 1'b1;
        #1;
        chk(irq_need === 1'b1, "R8 flag kept while masked", b2i(irq_need), 1);
        pulse_ack(1'b1, 1'b0);
        chk(irq_need === 1'b0, "R9 ack after unmask", b2i(irq_need), 0);
        wait_drain();
        pulse_ack(1'b0, 1'b1);

        // R6 R7: overwrite while waiting, then back-to-back frames
        exp_q.push_back(8'h11);
        do_write(8'h11);
        @(negedge clk);
        pulse_ack(1'b1, 1'b0);
        exp_q.push_back(8'hC7);
        do_write(8'h5A);
        do_write(8'hC7);
        chk(hold_full === 1'b1, "R7 pending byte held", b2i(hold_full), 1);
        chk(irq_need === 1'b0, "R6 no need while shifter busy", b2i(irq_need), 0);
        while (hold_full) @(negedge clk);
        chk(irq_need === 1'b1, "R6 need on copy at stop end", b2i(irq_need), 1);
        chk(irq_done === 1'b0, "R4 no done while byte waited", b2i(irq_done), 0);
        wait_drain();
        pulse_ack(1'b1, 1'b1);

        // random traffic, one byte at a time into an empty holding stage
        for (int i = 0; i < N_RAND; i++) begin
            logic [7:0] d;
            int gap;
            d   = 8'($urandom);
            gap = int'($urandom % 40);
            repeat (gap) @(negedge clk);
            while (hold_full) @(negedge clk);
            exp_q.push_back(d);
            do_write(d);
        end
        wait_drain();
        chk(exp_q.size() == 0, "R2 all random bytes sent", exp_q.size(), 0);
        chk(txd === 1'b1, "R1 idle after traffic", b2i(txd), 1);

        finished = 1'b1;
        report();
        $finish;
    end

endmodule